// File: doc/BRIEF.md
# Synchronous Burst SRAM

A synthesizable synchronous static RAM with four 9-bit byte lanes and a 2-bit internal burst address generator. All commands, addresses and write data are captured on the rising clock edge. A selected address strobe starts an access at the presented address. Later strobe-free cycles continue the burst, and each one either steps the burst address or repeats it. A deselect ends the burst.

Reads leave the array through one of two paths, chosen by a static mode input. The flow-through path bypasses the output register. The pipelined path adds one output register stage. The output-valid flag marks the cycles in which a read beat sits at the output stage. Output enable and sleep act on that flag without waiting for a clock edge. Writes can target chosen byte lanes through a qualified byte-write, or all lanes through a global write. A sleep input blocks every edge while keeping the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first read, `data_vld_o` is 0 and no burst is active.
- R2: A cycle with `ads_ni` low and the chip selected (`cs1_ni` low and `cs2_i` high) starts an access at `addr_i`. The access is a write if `gw_ni` is low, or if `bw_ni` is low and at least one `be_ni` bit is low. Otherwise it is a read.
- R3: In a byte write, only lane k is written where `be_ni[k]` is low. Lane k is data bits [9k+8:9k]. All other lanes keep their old contents.
- R4: With `gw_ni` low, all four lanes are written, whatever `bw_ni` and `be_ni` are.
- R5: With `pipe_i` low, read data and `data_vld_o` high appear in the cycle right after the edge that captured the read beat.
- R6: With `pipe_i` high, read data and `data_vld_o` high appear one cycle later than in R5.
- R7: While a burst is active, a cycle with `ads_ni` high and `adv_ni` low is a beat at the next count. With `lin_i` high, the low two address bits are the start bits plus the count, modulo 4.
- R8: With `lin_i` low, the low two address bits are the start bits XOR the count. The upper address bits stay fixed during a burst.
- R9: While a burst is active, a cycle with `ads_ni` high and `adv_ni` high repeats the current address.
- R10: A cycle with `ads_ni` low and the chip not selected writes nothing and ends the burst. Later strobe-free cycles do nothing. `data_vld_o` drops as soon as the last read beat already in flight has left, with no extra cycle.
- R11: `oe_ni` high forces `data_vld_o` low without waiting for a clock edge. The read stream underneath is not disturbed.
- R12: While `sleep_i` is high, `data_vld_o` is low and clock edges are ignored: no write, and no change to the burst state. Stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| ads_ni | input | 1 | Address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| addr_i | input | AW (8) | Word address |
| be_ni | input | LANES (4) | Per-lane byte enables, active low |
| bw_ni | input | 1 | Byte-write qualifier, active low |
| gw_ni | input | 1 | Global write, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| pipe_i | input | 1 | Read path: 1 pipelined, 0 flow-through |
| data_i | input | LANES*LW (36) | Write data |
| data_o | output | LANES*LW (36) | Read data |
| data_vld_o | output | 1 | Read data valid |

## Verification
A read beat captured at edge n is due at the output in the cycle after edge n in flow-through mode, and in the cycle after edge n+1 in pipelined mode. Writes update the array at the capturing edge. When the driver issues a beat, it computes the address from its own burst model and pushes the expected word together with the exact cycle in which it is due. The monitor samples on the falling edge, away from the capturing edge. If a queued item is due in that cycle, the monitor compares the word and the valid flag. In every other cycle it requires the valid flag to be low, which covers the single-cycle deselect rule. Output enable and sleep take effect in the same cycle they change. So the driver rewrites the expected valid flag of any item due in the next sample.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [1:0] {BEAT_NONE, BEAT_RD, BEAT_WR} beat_e;

  // low address bits of a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] count,
                                          input logic lin);
    return lin ? (start + count) : (start ^ count);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl import sbs_pkg::*; #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             ads_ni,
  input  logic             adv_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_ni,
  input  logic             bw_ni,
  input  logic             gw_ni,
  input  logic             sleep_i,
  input  logic             lin_i,
  output beat_e            beat_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] wmask_o
);
  logic          act_q, act_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          beat, sel;

  always_comb begin
    sel    = !cs1_ni && cs2_i;
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    beat   = 1'b0;
    if (!sleep_i) begin
      if (!ads_ni) begin
        act_d = sel;
        if (sel) begin
          base_d = addr_i;
          cnt_d  = '0;
          beat   = 1'b1;
        end
      end else if (act_q) begin
        beat = 1'b1;
        if (!adv_ni) cnt_d = cnt_q + 2'd1;
      end
    end
  end

  assign addr_o  = {base_d[AW-1:2], burst_lo(base_d[1:0], cnt_d, lin_i)};
  assign wmask_o = !gw_ni ? '1 : (!bw_ni ? ~be_ni : '0);
  assign beat_o  = !beat ? BEAT_NONE : ((|wmask_o) ? BEAT_WR : BEAT_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r9_suspend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o != BEAT_NONE && $past(beat_o != BEAT_NONE) && ads_ni && adv_ni && lin_i == $past(lin_i))
      |-> addr_o == $past(addr_o));
  a_r7_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o != BEAT_NONE && $past(beat_o != BEAT_NONE) && ads_ni && !adv_ni && lin_i && $past(lin_i))
      |-> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);
  a_r8_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o != BEAT_NONE && $past(beat_o != BEAT_NONE) && ads_ni)
      |-> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));
  a_r10_desel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !ads_ni && (cs1_ni || !cs2_i))
      |=> (!ads_ni || beat_o == BEAT_NONE));
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array import sbs_pkg::*; #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk_i,
  input  beat_e               beat_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES-1:0]    wmask_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (beat_i == BEAT_WR && wmask_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
      if (beat_i == BEAT_RD) rd_q <= mem[addr_i];
    end
    assign rdata_o[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/sbs_outpath.sv
`timescale 1ns/1ps
module sbs_outpath #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  input  logic          rd_beat_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o,
  output logic          vld_o
);
  logic          s1_q, s2_q;
  logic [DW-1:0] s2_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rd_beat_i;
      s2_q <= s1_q;
    end
  end

  // output register loads only when a read beat leaves the array
  always_ff @(posedge clk_i) begin
    if (s1_q) s2_data_q <= rdata_i;
  end

  assign data_o = pipe_i ? s2_data_q : rdata_i;
  assign vld_o  = (pipe_i ? s2_q : s1_q) && !oe_ni && !sleep_i;

  a_r12_sleep_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !s1_q);
  a_r5_flow_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && vld_o) |-> $past(rd_beat_i));
  a_r6_pipe_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && $past(pipe_i) && vld_o) |-> $past(rd_beat_i, 2));
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram import sbs_pkg::*; #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs1_ni,
  input  logic                cs2_i,
  input  logic                ads_ni,
  input  logic                adv_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES-1:0]    be_ni,
  input  logic                bw_ni,
  input  logic                gw_ni,
  input  logic                oe_ni,
  input  logic                sleep_i,
  input  logic                lin_i,
  input  logic                pipe_i,
  input  logic [LANES*LW-1:0] data_i,
  output logic [LANES*LW-1:0] data_o,
  output logic                data_vld_o
);
  localparam int DW = LANES * LW;

  beat_e            beat;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] wmask;
  logic [DW-1:0]    rdata;

  sbs_ctrl #(.AW(AW), .LANES(LANES)) i_ctrl (
    .clk_i, .rst_ni, .cs1_ni, .cs2_i, .ads_ni, .adv_ni, .addr_i,
    .be_ni, .bw_ni, .gw_ni, .sleep_i, .lin_i,
    .beat_o(beat), .addr_o(addr), .wmask_o(wmask)
  );

  sbs_array #(.AW(AW), .LANES(LANES), .LW(LW)) i_array (
    .clk_i, .beat_i(beat), .addr_i(addr), .wmask_i(wmask),
    .wdata_i(data_i), .rdata_o(rdata)
  );

  sbs_outpath #(.DW(DW)) i_out (
    .clk_i, .rst_ni, .pipe_i, .oe_ni, .sleep_i,
    .rd_beat_i(beat == BEAT_RD), .rdata_i(rdata),
    .data_o, .vld_o(data_vld_o)
  );

  a_r1_quiet_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !data_vld_o);
endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  localparam int AW = 8, LANES = 4, LW = 9, DW = LANES * LW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs1_ni = 1'b1, cs2_i = 1'b0, ads_ni = 1'b1, adv_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [LANES-1:0] be_ni = '1;
  logic bw_ni = 1'b1, gw_ni = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic lin_i = 1'b1, pipe_i = 1'b0;
  logic [DW-1:0] data_i = '0, data_o;
  logic data_vld_o;

  always #2 clk_i = ~clk_i;

  sync_burst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_sync_burst_sram (.*);

  typedef struct { int due; logic [DW-1:0] data; bit vld; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;
  logic [DW-1:0] ref_mem [1<<AW];
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  string tag = "R1";
  bit oe_n = 0, slp = 0, lin = 1, pipe = 0;
  bit m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // monitor: pops items when due, otherwise output must be idle (R10)
  always @(negedge clk_i) if (mon_on) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      cur = q.pop_front();
      if (cur.vld)
        chk(data_vld_o === 1'b1 && data_o === cur.data, cur.tag,
            {data_o[DW-2:0], data_vld_o}, {cur.data[DW-2:0], 1'b1});
      else
        chk(data_vld_o === 1'b0, cur.tag, {35'b0, data_vld_o}, '0);
    end else begin
      chk(data_vld_o === 1'b0, "R10", {35'b0, data_vld_o}, '0);
    end
  end

  task automatic step(logic a_n, logic v_n, logic c1_n, logic c2, logic g_n, logic b_n,
                      logic [LANES-1:0] e_n, logic [AW-1:0] a, logic [DW-1:0] d);
    bit beat;
    bit wr;
    logic [LANES-1:0] mask;
    logic [AW-1:0] ea;
    @(negedge clk_i);
    #1;
    ads_ni = a_n; adv_ni = v_n; cs1_ni = c1_n; cs2_i = c2; gw_ni = g_n; bw_ni = b_n;
    be_ni = e_n; addr_i = a; data_i = d; oe_ni = oe_n; sleep_i = slp; lin_i = lin; pipe_i = pipe;
    foreach (q[i]) if (q[i].due == cyc + 1) q[i].vld = !oe_n && !slp;
    beat = 0;
    if (!slp) begin
      if (!a_n) begin
        m_act = !c1_n && c2;
        if (m_act) begin m_base = a; m_cnt = '0; beat = 1; end
      end else if (m_act) begin
        beat = 1;
        if (!v_n) m_cnt = m_cnt + 2'd1;
      end
    end
    if (beat) begin
      ea = {m_base[AW-1:2], lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt};
      mask = !g_n ? '1 : (!b_n ? ~e_n : '0);
      wr = (mask != '0);
      if (wr) begin
        for (int k = 0; k < LANES; k++)
          if (mask[k]) ref_mem[ea][k*LW +: LW] = d[k*LW +: LW];
      end else begin
        q.push_back('{due: cyc + (pipe ? 2 : 1), data: ref_mem[ea],
                      vld: pipe ? 1'b1 : (!oe_n && !slp), tag: tag});
      end
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic g_n, logic b_n, logic [3:0] e_n);
    step(1'b0, 1'b1, 1'b0, 1'b1, g_n, b_n, e_n, a, d);
  endtask
  task automatic rs(logic [AW-1:0] a); step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, a, '0); endtask
  task automatic rn(logic v_n); step(1'b1, v_n, 1'b0, 1'b1, 1'b1, 1'b1, '1, '0, '0); endtask
  task automatic ds(); step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, '0, '0); endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(data_vld_o === 1'b0, "R1", {35'b0, data_vld_o}, '0);
    @(negedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(data_vld_o === 1'b0, "R1", {35'b0, data_vld_o}, '0);
    #1 mon_on = 1;

    tag = "R2";  wr(8'h10, 36'h123456789, 1, 1, 4'hF); // gw high, bw high: read (R2)
    wr(8'h10, 36'h123456789, 0, 1, 4'hF); rs(8'h10); ds(); ds();
    tag = "R3";  wr(8'h10, 36'hABCDEF012, 1, 0, 4'b1010); rs(8'h10); ds();
    tag = "R4";  wr(8'h11, 36'h0F0F0F0F0, 0, 1, 4'hF);
    wr(8'h12, 36'h987654321, 0, 0, 4'b1110); rs(8'h11); rs(8'h12); ds();
    tag = "R2";  wr(8'h11, 36'h555555555, 1, 1, 4'h0); ds();
    tag = "R10";
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '1, 8'h11, 36'hFFFFFFFFF);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '1, 8'h11, 36'hFFFFFFFFF);
    rs(8'h11); ds(); rn(1'b0); rn(1'b1); ds();
    tag = "R7";
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(i), 36'h100000000 * (i + 1) + 36'(i * 17), 0, 1, 4'hF);
    rs(8'h22); rn(1'b0); rn(1'b0); rn(1'b0); ds();
    lin = 0; tag = "R8"; rs(8'h21); rn(1'b0); rn(1'b0); rn(1'b0); ds(); lin = 1;
    tag = "R9"; rs(8'h20); rn(1'b1); rn(1'b0); rn(1'b1); ds(); ds(); ds();
    pipe = 1; tag = "R6"; ds(); ds();
    rs(8'h23); rn(1'b0); rn(1'b0); rn(1'b0); ds(); rs(8'h20); ds(); ds(); ds();
    pipe = 0; ds(); ds();
    tag = "R11"; rs(8'h21); oe_n = 1; rn(1'b1); rn(1'b1); oe_n = 0; rn(1'b1); ds();
    tag = "R12"; slp = 1; wr(8'h21, 36'hFFFFFFFFF, 0, 1, 4'hF); slp = 0; rs(8'h21); ds();
    rs(8'h22); slp = 1; rn(1'b0); rn(1'b0); slp = 0; rn(1'b0); ds();
    ds(); ds(); ds();
    @(negedge clk_i);
    chk(q.size() == 0, "R10", 36'(q.size()), '0);
    mon_on = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule